// File: doc/BRIEF.md
# Single-Period Reference Clock Monitor

This block watches four reference clocks that arrive asynchronously to a free-running 100 MHz system clock. Each reference is synchronised into the system domain. The block then counts the system-clock cycles between consecutive rising edges, so every period is measured in 10 ns units. Each finished period is checked against a window that software sets for that reference. Any period shorter than the window's lower bound or longer than its upper bound marks the reference as failed.

Each reference also has a timeout. If the running count goes past the upper bound before the next edge arrives, the reference is flagged at once. This makes a stopped clock visible without waiting for an edge. A failed reference is cleared by the next in-range period. A per-reference mask hides failures from the status outputs without losing them.

Software uses a synchronous write port and a combinational read port. Through them it programs the limits and the mask, and reads back the limits, the mask and the masked status.

Top module: `refmon`

## Requirements
- R1: After reset every lower limit reads 0, every upper limit reads 16'hFFFF, the mask reads 0 and the status outputs are all 0.
- R2: Register map for `addr`:
  - Addresses 0 to 3 hold the lower limit of references 0 to 3.
  - Addresses 4 to 7 hold the upper limit of references 0 to 3.
  - Address 8 holds the 16-bit mask, and its bit i masks reference i.
  - Address 9 reads the masked status in bits 3:0, with the upper bits zero. Writes to it are ignored.
  - Any other address reads 0.
  - A write takes effect on the clock edge where `wr_en` is high. `rd_data` follows `addr` combinationally.
- R3: A period is the number of system-clock cycles from one rising edge of a reference to the next. When a period completes, the reference is failed if the period is below its lower limit or above its upper limit. Both bounds are inclusive. The verdict appears on `status` no more than 4 cycles after the rising edge reaches the input.
- R4: If a reference's running count exceeds its upper limit before the next edge arrives, that reference is flagged failed without waiting for an edge. Once the count first exceeds the limit, the flag appears within 3 cycles.
- R5: A failed reference stays failed until a period inside its window completes, and that period clears it.
- R6: The period counter holds at 16'hFFFF instead of wrapping. A reference that stays stopped for more than 65535 cycles therefore measures as out of range at its next edge.
- R7: `status[i]` is the failure of reference i gated off by mask bit i. Masking does not clear the underlying failure, which shows again as soon as the mask bit is cleared.
- R8: Writing either limit of a reference clears its failure and discards the period in progress. The next rising edge only starts a new measurement.
- R9: The four monitors are independent: a failure of one reference never changes another reference's status bit.
- R10: After reset, the first rising edge of a reference starts measurement and gives no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz system clock, the measurement time base |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 4 | Reference clocks, asynchronous to `clk` |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for both reads and writes |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data for `addr` |
| status | output | 4 | Masked per-reference failure flags |

## Verification
The hardest case to reach from the ports is a counter that has been stopped long enough to saturate. A wrapping counter looks exactly like a saturating one until a fresh edge makes the wrapped value fall inside the window. The bench therefore sets a window that starts at zero and holds that reference idle for just over 65536 cycles. It then restarts the reference, so that a wrapped count would land in range and wrongly clear the flag.

The discard of a partial period after a limit write is checked in a similar way. The rewrite happens mid-period, and the lower limit is chosen so that the truncated interval would fail if it were ever judged.

// File: rtl/refmon.sv
module refmon #(
  parameter int NREF = 4,
  parameter int W    = 16,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREF-1:0] ref_in,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [W-1:0]    wr_data,
  output logic [W-1:0]    rd_data,
  output logic [NREF-1:0] status
);
  localparam logic [AW-1:0] MASK_A = AW'(2*NREF);
  localparam logic [AW-1:0] STAT_A = AW'(2*NREF + 1);
  localparam logic [W-1:0]  CMAX   = {W{1'b1}};

  logic [NREF-1:0]        s1, s2, s3, rise, wr_lim, raw_q, armed_q;
  logic [NREF-1:0][W-1:0] lo_q, hi_q, cnt_q;
  logic [W-1:0]           mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
      mask_q <= '0;
    end else begin
      s1 <= ref_in;
      s2 <= s1;
      s3 <= s2;
      if (wr_en && addr == MASK_A) mask_q <= wr_data;
    end
  end

  assign rise   = s2 & ~s3;
  assign status = raw_q & ~mask_q[NREF-1:0];

  for (genvar i = 0; i < NREF; i++) begin : g_mon
    logic [W-1:0] lo, hi, cnt;
    logic         raw, armed;
    logic         lo_hit, hi_hit;

    assign lo_hit    = wr_en && addr == AW'(i);
    assign hi_hit    = wr_en && addr == AW'(NREF + i);
    assign wr_lim[i] = lo_hit || hi_hit;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo    <= '0;
        hi    <= CMAX;
        cnt   <= '0;
        raw   <= 1'b0;
        armed <= 1'b0;
      end else begin
        if (lo_hit) lo <= wr_data;
        if (hi_hit) hi <= wr_data;
        if (wr_lim[i]) begin
          cnt   <= '0;
          raw   <= 1'b0;
          armed <= 1'b0;
        end else if (rise[i]) begin
          cnt   <= W'(1);
          armed <= 1'b1;
          if (armed) raw <= (cnt < lo) || (cnt > hi);
        end else begin
          if (cnt != CMAX) cnt <= cnt + W'(1);
          if (cnt > hi) raw <= 1'b1;
        end
      end
    end

    assign lo_q[i]    = lo;
    assign hi_q[i]    = hi;
    assign cnt_q[i]   = cnt;
    assign raw_q[i]   = raw;
    assign armed_q[i] = armed;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREF; i++) begin
      if (addr == AW'(i))        rd_data = lo_q[i];
      if (addr == AW'(NREF + i)) rd_data = hi_q[i];
    end
    if (addr == MASK_A) rd_data = mask_q;
    if (addr == STAT_A) rd_data = W'(status);
  end
endmodule

module refmon_chk #(
  parameter int NREF = 4,
  parameter int W    = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NREF-1:0]        rise,
  input logic [NREF-1:0]        wr_lim,
  input logic [NREF-1:0]        armed_q,
  input logic [NREF-1:0]        raw_q,
  input logic [NREF-1:0][W-1:0] cnt_q,
  input logic [NREF-1:0][W-1:0] hi_q
);
  for (genvar i = 0; i < NREF; i++) begin : g_chk
    a_r8_disarm: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lim[i] |=> !armed_q[i] && !raw_q[i]);

    a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[i] == {W{1'b1}} && !rise[i] && !wr_lim[i]) |=> cnt_q[i] == {W{1'b1}});

    a_r4_lost: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[i] > hi_q[i] && !wr_lim[i] && (armed_q[i] || !rise[i])) |=> raw_q[i]);

    a_r5_clear_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(raw_q[i]) |-> ($past(rise[i] && armed_q[i]) || $past(wr_lim[i])));

    a_r10_first_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (rise[i] && !armed_q[i] && !wr_lim[i]) |=> raw_q[i] == $past(raw_q[i]));
  end
endmodule

bind refmon refmon_chk #(.NREF(NREF), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rise(rise), .wr_lim(wr_lim),
  .armed_q(armed_q), .raw_q(raw_q), .cnt_q(cnt_q), .hi_q(hi_q)
);

// File: tb/test_refmon.sv
module test_refmon;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0]  ref_in = '0, addr = '0, status;
  logic [15:0] wr_data = '0, rd_data, rv;
  int errs = 0, checks = 0;

  refmon i_refmon (.clk(clk), .rst_n(rst_n), .ref_in(ref_in), .wr_en(wr_en),
                   .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .status(status));

  always #4 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  // one period of p cycles on reference r; optionally judges the previous period 4 cycles in
  task automatic send(input int r, input int p, input bit do_chk, input logic [3:0] exp, input string req);
    ref_in[r] = 1'b1;
    tick(4);
    if (do_chk) chk(req, 16'(status), 16'(exp));
    tick(p/2 - 4);
    ref_in[r] = 1'b0;
    tick(p - p/2);
  endtask

  function automatic bit outside(input int p, input int lo, input int hi);
    return (p < lo) || (p > hi);
  endfunction

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);

    // R1 reset values
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), rv);
      chk("R1", rv, (a >= 4 && a < 8) ? 16'hFFFF : 16'h0);
    end
    chk("R1", 16'(status), 16'h0);

    // R2 register map
    for (int a = 0; a < 8; a++) wr(4'(a), 16'(16'h1200 + a * 16'h0111));
    wr(8, 16'hA5A0);
    wr(9, 16'hFFFF);
    for (int a = 0; a < 8; a++) begin
      rd(4'(a), rv);
      chk("R2", rv, 16'(16'h1200 + a * 16'h0111));
    end
    rd(8, rv);  chk("R2", rv, 16'hA5A0);
    rd(9, rv);  chk("R2", rv, 16'h0000);
    rd(10, rv); chk("R2", rv, 16'h0000);
    for (int a = 0; a < 4; a++) begin
      wr(4'(a + 4), 16'hFFFF);
      wr(4'(a), 16'h0);
    end
    wr(8, 16'h0);

    // R3/R5/R9/R10: sweep every reference across its window
    for (int r = 0; r < 4; r++) begin
      int lo, hi, prevp;
      lo = 12 + 2*r;
      hi = lo + 6 + r;
      wr(4'(4 + r), 16'(hi));
      wr(4'(r), 16'(lo));
      send(r, lo + 1, 1, 4'h0, "R10");
      prevp = lo + 1;
      for (int p = lo - 3; p <= hi + 3; p++) begin
        bit pf, nf;
        pf = outside(prevp, lo, hi);
        send(r, p, 1, pf ? 4'(1 << r) : 4'h0, "R3");
        nf = outside(p, lo, hi);
        if (pf && !nf) begin
          ref_in[r] = 1'b1; tick(4);
          chk("R5", 16'(status), 16'h0);
          ref_in[r] = 1'b0;
          break;
        end
        prevp = p;
      end
      tick(20);
      send(r, lo + 2, 0, 4'h0, "R3");
      send(r, hi + 3, 0, 4'h0, "R3");
      ref_in[r] = 1'b1; tick(4);
      chk("R9", 16'(status), 16'(1 << r));
      ref_in[r] = 1'b0;
      wr(4'(4 + r), 16'hFFFF);
      chk("R8", 16'(status), 16'h0);
    end

    // R3 upper boundary sweep on ref 3 (window 30..36)
    wr(7, 36); wr(3, 30);
    send(3, 33, 0, 4'h0, "R3");
    for (int p = 34; p <= 38; p++) begin
      send(3, p, 1, 4'h0, "R3");
      send(3, 33, 1, outside(p, 30, 36) ? 4'h8 : 4'h0, "R3");
    end
    tick(2);
    wr(7, 16'hFFFF);

    // R4 lost reference, then R7 masking
    wr(5, 30); wr(1, 12);
    send(1, 20, 0, 4'h0, "R4");
    send(1, 20, 1, 4'h0, "R3");
    ref_in[1] = 1'b1; tick(5);
    ref_in[1] = 1'b0; tick(27);
    chk("R4", 16'(status), 16'h0);
    tick(3);
    chk("R4", 16'(status), 16'h2);
    wr(8, 16'h0002);
    chk("R7", 16'(status), 16'h0);
    rd(9, rv); chk("R7", rv, 16'h0);
    wr(8, 16'h0);
    chk("R7", 16'(status), 16'h2);
    rd(9, rv); chk("R7", rv, 16'h2);
    wr(5, 16'hFFFF);
    chk("R8", 16'(status), 16'h0);

    // R8 limit write mid-period discards the partial period
    wr(4, 40); wr(0, 20);
    send(0, 25, 0, 4'h0, "R8");
    send(0, 25, 1, 4'h0, "R3");
    send(0, 50, 1, 4'h0, "R3");
    ref_in[0] = 1'b1; tick(4);
    chk("R3", 16'(status), 16'h1);
    tick(6);
    wr(4, 60);
    chk("R8", 16'(status), 16'h0);
    tick(1); ref_in[0] = 1'b0; tick(1);
    send(0, 50, 1, 4'h0, "R8");
    send(0, 30, 1, 4'h0, "R8");
    tick(2);
    wr(4, 16'hFFFF);

    // R6 saturation on ref 2: window 0..100, idle past counter range
    wr(6, 100); wr(2, 0);
    ref_in[2] = 1'b1; tick(4);
    ref_in[2] = 1'b0;
    tick(65536 + 60);
    chk("R6", 16'(status), 16'h4);
    send(2, 40, 1, 4'h4, "R6");
    send(2, 40, 1, 4'h0, "R5");
    wr(6, 16'hFFFF);
    chk("R1", 16'(status), 16'h0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule